// File: doc/BRIEF.md
# Dual Decade Counter with Split Binary and Quinary Stages

The block contains two identical decade counters. Each counter is built from two stages that have their own clocks: a one-bit toggle stage and a three-bit modulo-5 stage. Both stages move on the falling edge of their own clock. Because the stages are separate, the wiring outside the block decides how they combine. Feeding the toggle output into the quinary clock gives a BCD digit. Feeding the top quinary bit into the toggle clock gives a bi-quinary count, whose toggle output is a square wave at one tenth of the input rate with 50% duty.

Each counter has its own asynchronous clear, which is active high. While the clear is high, all four of that counter's bits are low and both of its clocks are ignored. The clear has no effect on the other counter. The two counters can be chained outside the block to divide by 2, 4, 5, 10, 20, 25, 50 or 100.

Top module: `dual_decade_counter`

## Requirements
- R1: The toggle bit QA of a counter inverts on each falling edge of that counter's toggle clock. A rising edge leaves it unchanged.
- R2: The quinary state is (QD,QC,QB), with QB as the LSB. On each falling edge of the quinary clock it steps 0,1,2,3,4 and then returns to 0.
- R3: While a counter's clear is high, its four bits read 0 immediately, without waiting for a clock edge. Falling clock edges during the clear do not move the counter. After the clear is released, counting restarts from 0.
- R4: The clear of one counter does not change the bits of the other counter.
- R5: q_o[4u+3:4u] carries {QD,QC,QB,QA} of counter u. With QA wired to the quinary clock, that nibble counts 0 to 9 in BCD and returns to 0.
- R6: With QD wired to the toggle clock, after n falling quinary edges the state is n mod 5 and QA equals floor(n/5) mod 2. This gives a divide-by-10 output with 50% duty.
- R7: When counter 0 runs in BCD and its QD drives the toggle clock of counter 1, which also runs in BCD, the two nibbles show n mod 10 and floor(n/10) mod 10. Both nibbles return to 0 after 100 input edges.
- R8: Chaining QA of counter 0 into the toggle clock of counter 1 divides by 4. Chaining QD of counter 0 into the quinary clock of counter 1 divides by 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | NUM_UNITS (2) | Toggle-stage clock of each counter; acts on the falling edge |
| clk_b_i | input | NUM_UNITS (2) | Quinary-stage clock of each counter; acts on the falling edge |
| clr_i | input | NUM_UNITS (2) | Asynchronous clear of each counter, active high |
| q_o | output | 4*NUM_UNITS (8) | Counter u occupies bits [4u+3:4u] as {QD,QC,QB,QA} |

## Verification
A fault in the toggle stage shows on QA at the first falling edge of its clock. A fault in the quinary stage shows on QB..QD within five edges, because the wrap from 4 to 0 is reached by then. In the chained modes, the same fault spreads into the BCD digit sequence and into the other counter. A wrong carry timing therefore appears within ten input edges for a single decade and within one hundred edges for the cascade. A clear that is late, or that reaches the wrong counter, is visible on the outputs in the same timestep the clear rises.

// File: rtl/dual_decade_pkg.sv
package dual_decade_pkg;
  localparam int unsigned QUINT_W    = 3;
  localparam int unsigned QUINT_MOD  = 5;
  localparam int unsigned DIGIT_W    = QUINT_W + 1;

  typedef struct packed {
    logic [QUINT_W-1:0] quint;  // {qd,qc,qb}
    logic               qa;
  } digit_t;
endpackage

// File: rtl/biq_toggle_stage.sv
module biq_toggle_stage (
  input  logic clk_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i) q_o <= 1'b0;
    else       q_o <= ~q_o;
  end

  // marks that an edge occurred since the last clear
  logic seen_q;
  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i) seen_q <= 1'b0;
    else       seen_q <= 1'b1;
  end

  p_toggle_r1: assert property (@(negedge clk_i) disable iff (clr_i)
    seen_q |-> (q_o != $past(q_o)));

  p_clear_holds_r3: assert property (@(negedge clk_i)
    clr_i |-> (q_o == 1'b0));
endmodule

// File: rtl/biq_quint_stage.sv
module biq_quint_stage
  import dual_decade_pkg::*;
#(
  parameter int unsigned W   = QUINT_W,
  parameter int unsigned MOD = QUINT_MOD
) (
  input  logic         clk_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] LAST = W'(MOD - 1);

  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i)            q_o <= '0;
    else if (q_o >= LAST) q_o <= '0;
    else                  q_o <= q_o + 1'b1;
  end

  logic seen_q;
  always_ff @(negedge clk_i or posedge clr_i) begin
    if (clr_i) seen_q <= 1'b0;
    else       seen_q <= 1'b1;
  end

  p_in_range_r2: assert property (@(negedge clk_i) disable iff (clr_i)
    q_o <= LAST);

  p_step_r2: assert property (@(negedge clk_i) disable iff (clr_i)
    (seen_q && $past(q_o) == LAST) |-> (q_o == '0));

  p_clear_holds_r3: assert property (@(negedge clk_i)
    clr_i |-> (q_o == '0));
endmodule

// File: rtl/biq_decade.sv
module biq_decade
  import dual_decade_pkg::*;
(
  input  logic   clk_a_i,
  input  logic   clk_b_i,
  input  logic   clr_i,
  output digit_t q_o
);
  biq_toggle_stage u_toggle (
    .clk_i (clk_a_i),
    .clr_i (clr_i),
    .q_o   (q_o.qa)
  );

  biq_quint_stage #(
    .W   (QUINT_W),
    .MOD (QUINT_MOD)
  ) u_quint (
    .clk_i (clk_b_i),
    .clr_i (clr_i),
    .q_o   (q_o.quint)
  );
endmodule

// File: rtl/dual_decade_counter.sv
module dual_decade_counter
  import dual_decade_pkg::*;
#(
  parameter int unsigned NUM_UNITS = 2
) (
  input  logic [NUM_UNITS-1:0]         clk_a_i,
  input  logic [NUM_UNITS-1:0]         clk_b_i,
  input  logic [NUM_UNITS-1:0]         clr_i,
  output logic [NUM_UNITS*DIGIT_W-1:0] q_o
);
  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    digit_t dig;

    biq_decade u_decade (
      .clk_a_i (clk_a_i[u]),
      .clk_b_i (clk_b_i[u]),
      .clr_i   (clr_i[u]),
      .q_o     (dig)
    );

    assign q_o[u*DIGIT_W +: DIGIT_W] = dig;
  end
endmodule

// File: tb/dual_decade_counter_tb_top.sv
module dual_decade_counter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  typedef enum logic [2:0] {M_INDEP, M_BCD, M_BIQ, M_CASC, M_DIV4, M_DIV25} mode_t;

  int checks = 0;
  int errors = 0;

  mode_t      mode = M_INDEP;
  logic [1:0] src_a = 2'b11;
  logic [1:0] src_b = 2'b11;
  logic [1:0] clr = 2'b11;
  logic [1:0] clk_a, clk_b;
  logic [7:0] q;

  // external strapping
  always_comb begin
    clk_a = src_a;
    clk_b = src_b;
    case (mode)
      M_BCD:   begin clk_b[0] = q[0]; clk_b[1] = q[4]; end
      M_BIQ:   begin clk_a[0] = q[3]; clk_a[1] = q[7]; end
      M_CASC:  begin clk_b[0] = q[0]; clk_a[1] = q[3]; clk_b[1] = q[4]; end
      M_DIV4:  clk_a[1] = q[0];
      M_DIV25: clk_b[1] = q[3];
      default: ;
    endcase
  end

  dual_decade_counter #(.NUM_UNITS(2)) dut_i (
    .clk_a_i (clk_a),
    .clk_b_i (clk_b),
    .clr_i   (clr),
    .q_o     (q)
  );

  function automatic int nib(input int u);
    return int'(q[4*u +: 4]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input bit on_b, input int u);
    if (on_b) src_b[u] = 1'b0; else src_a[u] = 1'b0;
    #HALF;
    if (on_b) src_b[u] = 1'b1; else src_a[u] = 1'b1;
    #HALF;
  endtask

  task automatic set_mode(input mode_t m);
    clr = 2'b11;
    #HALF;
    mode = m;
    #HALF;
    clr = 2'b00;
    #HALF;
  endtask

  task automatic t_reset_r3;
    #1;
    check(q == 8'h00, "R3 reset", int'(q), 0);
  endtask

  task automatic t_toggle_r1;
    set_mode(M_INDEP);
    for (int i = 1; i <= 4; i++) begin
      src_a[0] = 1'b0;
      #1;
      check(q[0] == 1'(i % 2), "R1 fall", int'(q[0]), i % 2);
      #(HALF - 1);
      src_a[0] = 1'b1;
      #1;
      check(q[0] == 1'(i % 2), "R1 rise", int'(q[0]), i % 2);
      #(HALF - 1);
    end
    check(nib(1) == 0, "R1 other unit", nib(1), 0);
  endtask

  task automatic t_quint_r2;
    set_mode(M_INDEP);
    for (int n = 1; n <= 12; n++) begin
      pulse(1'b1, 0);
      check(int'(q[3:1]) == n % 5, "R2 quint", int'(q[3:1]), n % 5);
      check(q[0] == 1'b0, "R2 qa idle", int'(q[0]), 0);
    end
  endtask

  task automatic t_clear_r3_r4;
    int keep;
    set_mode(M_INDEP);
    pulse(1'b1, 0); pulse(1'b1, 0); pulse(1'b0, 0);  // unit0 = 5
    pulse(1'b1, 1); pulse(1'b1, 1); pulse(1'b1, 1); pulse(1'b0, 1);  // unit1 = 7
    check(nib(0) == 5, "R3 pre", nib(0), 5);
    keep = nib(1);
    clr[0] = 1'b1;
    #1;
    check(nib(0) == 0, "R3 async", nib(0), 0);
    check(nib(1) == keep, "R4 isolate", nib(1), keep);
    pulse(1'b1, 0); pulse(1'b0, 0);
    check(nib(0) == 0, "R3 override", nib(0), 0);
    clr[0] = 1'b0;
    #HALF;
    pulse(1'b1, 0);
    check(nib(0) == 2, "R3 restart", nib(0), 2);
    clr[1] = 1'b1;
    #1;
    check(nib(1) == 0, "R4 clear1", nib(1), 0);
    check(nib(0) == 2, "R4 keep0", nib(0), 2);
    clr[1] = 1'b0;
    #HALF;
  endtask

  task automatic t_bcd_r5;
    set_mode(M_BCD);
    for (int n = 1; n <= 25; n++) begin
      pulse(1'b0, 0);
      check(nib(0) == n % 10, "R5 bcd", nib(0), n % 10);
    end
  endtask

  task automatic t_biq_r6;
    int highs = 0;
    set_mode(M_BIQ);
    for (int n = 1; n <= 20; n++) begin
      pulse(1'b1, 0);
      check(int'(q[3:1]) == n % 5, "R6 quint", int'(q[3:1]), n % 5);
      check(int'(q[0]) == (n / 5) % 2, "R6 qa", int'(q[0]), (n / 5) % 2);
      highs += int'(q[0]);
    end
    check(highs == 10, "R6 duty", highs, 10);
  endtask

  task automatic t_casc_r7;
    set_mode(M_CASC);
    for (int n = 1; n <= 105; n++) begin
      pulse(1'b0, 0);
      check(nib(0) == n % 10 && nib(1) == (n / 10) % 10, "R7 cascade",
            nib(1) * 10 + nib(0), n % 100);
    end
  endtask

  task automatic t_ratio_r8;
    set_mode(M_DIV4);
    for (int n = 1; n <= 8; n++) begin
      pulse(1'b0, 0);
      check(int'(q[4]) == (n / 2) % 2, "R8 div4", int'(q[4]), (n / 2) % 2);
    end
    set_mode(M_DIV25);
    for (int n = 1; n <= 30; n++) begin
      pulse(1'b1, 0);
      check(int'(q[7:5]) == (n / 5) % 5, "R8 div25", int'(q[7:5]), (n / 5) % 5);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset_r3();
    t_toggle_r1();
    t_quint_r2();
    t_clear_r3_r4();
    t_bcd_r5();
    t_biq_r6();
    t_casc_r7();
    t_ratio_r8();
    finish_run();
  end
endmodule